// File: doc/BRIEF.md
# Variable-Cycle PWM Counter Unit

The block runs one free-running up-counter and drives a parameterised number of PWM channels from it. Every channel shares a cycle length picked at run time from 8, 9, 10 or 11 counter bits. A channel's output stays high while the low bits of the counter within the chosen length are below that channel's active compare value.

Each channel also holds a shadow reload value. This value is reached through the same bus addresses as the compare value: a bank bit in the configuration register decides which of the two an access reaches. In the 9, 10 and 11-bit lengths, the active compare value is replaced by the reload value at every cycle boundary, so a duty change lands cleanly on a period edge. In the 8-bit length the shadow values are never used.

A sticky cycle flag marks every period boundary. An enable bit gates it onto a single interrupt line. Software uses a byte-wide register bus with a combinational read port to configure the block, to load duties and to read the counter.

Top module: `vcpwm_unit`

## Requirements
- R1: The configuration register at address 0 holds the bank bit in bit 7, the interrupt enable in bit 6, the cycle flag in bit 5 and the length code in bits 1:0. Bits 4:2 always read 0, whatever was written to them.
- R2: After reset the counter is 0. It advances by one on each clock with `run_i` high, holds while `run_i` is low, and wraps to 0 after its all-ones value. Its low byte reads at address 1 and its high byte at address 2.
- R3: The length code selects the cycle length: 0 gives 8 bits, 1 gives 9, 2 gives 10 and 3 gives 11. The cycle flag sets on a counting clock whose low N counter bits are all ones, and only then.
- R4: The cycle flag is sticky. A configuration write with bit 5 at 1 sets it. Only a configuration write with bit 5 at 0 clears it.
- R5: When a hardware set and a software clear of the cycle flag fall in the same clock, the flag ends up set.
- R6: `irq_o` is high exactly when the cycle flag and the interrupt enable are both 1.
- R7: Channel c occupies address 4+2c for value bits 7:0 and address 5+2c for value bits 11:8, and bits 7:4 of the high byte read 0. With the bank bit at 0, accesses reach the active compare value. With it at 1, they reach the reload value. The value in the other bank stays unchanged.
- R8: A channel output is high while the counter's low N bits are below its active compare value. A compare value of 0 keeps it low, and a value of 2^N or more keeps it high.
- R9: In the 9, 10 and 11-bit lengths, each channel copies its reload value into its active compare value on the clock that sets the cycle flag. In the 8-bit length, the reload values have no effect.
- R10: Reset clears every register. After reset all PWM outputs and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW = clog2(4+2*NUM_CH) | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pwm_o | output | NUM_CH | Per-channel PWM outputs |
| irq_o | output | 1 | Cycle interrupt |

## Verification
The bench builds the unit with NUM_CH = 3 and CNT_W = 12. With this counter width the full 11-bit cycle and the wrap of the whole counter both fall within a few thousand clocks, so every length code can be driven across its boundary and the counter can be walked to its all-ones value and wrapped. Three channels are enough to have one channel at compare 0, one mid-range and one at 2^N side by side. They also let reload behaviour be compared between a 9-bit channel and an 8-bit channel.

// File: rtl/vcpwm_pkg.sv
package vcpwm_pkg;

  localparam int MAX_LEN = 11;
  localparam int CMP_W   = MAX_LEN + 1;

  localparam int BIT_BANK = 7;
  localparam int BIT_IE   = 6;
  localparam int BIT_FLAG = 5;

  typedef enum logic [1:0] {
    LEN_8  = 2'd0,
    LEN_9  = 2'd1,
    LEN_10 = 2'd2,
    LEN_11 = 2'd3
  } cyc_len_e;

  typedef struct packed {
    logic     bank;
    logic     irq_en;
    logic     flag;
    cyc_len_e len;
  } cfg_t;

  function automatic logic [MAX_LEN-1:0] len_mask(cyc_len_e l);
    case (l)
      LEN_8:   return 11'h0ff;
      LEN_9:   return 11'h1ff;
      LEN_10:  return 11'h3ff;
      default: return 11'h7ff;
    endcase
  endfunction

endpackage

// File: rtl/vcpwm_timebase.sv
module vcpwm_timebase
  import vcpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  cyc_len_e         len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cyc_ovf_o
);

  logic [MAX_LEN-1:0] mask;
  logic [MAX_LEN-1:0] low;

  assign mask      = len_mask(len_i);
  assign low       = cnt_o[MAX_LEN-1:0] & mask;
  // carry out of bit N-1 on this counting clock
  assign cyc_ovf_o = run_i && (low == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (run_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_o));

  a_r3_ovf_wraps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_ovf_o |=> ((cnt_o[MAX_LEN-1:0] & $past(mask)) == '0));

endmodule

// File: rtl/vcpwm_cfg.sv
module vcpwm_cfg
  import vcpwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       hw_set_i,
  output cfg_t       cfg_o
);

  logic unused_pad;
  assign unused_pad = ^wdata_i[4:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else begin
      if (wr_i) begin
        cfg_o.bank   <= wdata_i[BIT_BANK];
        cfg_o.irq_en <= wdata_i[BIT_IE];
        cfg_o.len    <= cyc_len_e'(wdata_i[1:0]);
      end
      // hardware set has priority over a software clear
      if (hw_set_i)  cfg_o.flag <= 1'b1;
      else if (wr_i) cfg_o.flag <= wdata_i[BIT_FLAG];
    end
  end

  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o.flag && !wr_i) |=> cfg_o.flag);

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i |=> cfg_o.flag);

  a_r4_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_o.flag) |-> ($past(hw_set_i) || $past(wr_i && wdata_i[BIT_FLAG])));

endmodule

// File: rtl/vcpwm_chan.sv
module vcpwm_chan
  import vcpwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         cmp_wr_i,   // [0] low byte, [1] high byte
  input  logic [1:0]         rld_wr_i,
  input  logic [7:0]         wdata_i,
  input  logic               reload_i,
  input  logic [MAX_LEN-1:0] phase_i,
  output logic [CMP_W-1:0]   cmp_o,
  output logic [CMP_W-1:0]   rld_o,
  output logic               pwm_o
);

  localparam int HI_W = CMP_W - 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_o <= '0;
    end else begin
      if (rld_wr_i[0]) rld_o[7:0]       <= wdata_i;
      if (rld_wr_i[1]) rld_o[CMP_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  // a software write in the same clock overrides the period-edge copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o <= '0;
    end else begin
      if (reload_i)    cmp_o                <= rld_o;
      if (cmp_wr_i[0]) cmp_o[7:0]           <= wdata_i;
      if (cmp_wr_i[1]) cmp_o[CMP_W-1:8]     <= wdata_i[HI_W-1:0];
    end
  end

  assign pwm_o = {1'b0, phase_i} < cmp_o;

  a_r9_reload_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && cmp_wr_i == 2'b00) |=> (cmp_o == $past(rld_o)));

  a_r7_cmp_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_wr_i != 2'b00 && cmp_wr_i == 2'b00 && !reload_i) |=> $stable(cmp_o));

  a_r7_rld_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr_i != 2'b00 && rld_wr_i == 2'b00) |=> $stable(rld_o));

endmodule

// File: rtl/vcpwm_unit.sv
module vcpwm_unit
  import vcpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(4 + 2 * NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);

  localparam logic [AW-1:0] A_CFG    = AW'(0);
  localparam logic [AW-1:0] A_CNT_LO = AW'(1);
  localparam logic [AW-1:0] A_CNT_HI = AW'(2);

  cfg_t               cfg;
  logic [CNT_W-1:0]   cnt;
  logic [15:0]        cnt_rd;
  logic               cyc_ovf;
  logic               reload;
  logic [MAX_LEN-1:0] phase;
  logic [CMP_W-1:0]   cmp_q [NUM_CH];
  logic [CMP_W-1:0]   rld_q [NUM_CH];

  vcpwm_cfg i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && addr_i == A_CFG),
    .wdata_i  (wdata_i),
    .hw_set_i (cyc_ovf),
    .cfg_o    (cfg)
  );

  vcpwm_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .len_i     (cfg.len),
    .cnt_o     (cnt),
    .cyc_ovf_o (cyc_ovf)
  );

  assign phase  = cnt[MAX_LEN-1:0] & len_mask(cfg.len);
  assign reload = cyc_ovf && (cfg.len != LEN_8);
  assign cnt_rd = 16'(cnt);
  assign irq_o  = cfg.flag & cfg.irq_en;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [AW-1:0] A_LO = AW'(4 + 2 * c);
    localparam logic [AW-1:0] A_HI = AW'(5 + 2 * c);
    logic [1:0] sel;
    assign sel = {wr_en_i && addr_i == A_HI, wr_en_i && addr_i == A_LO};

    vcpwm_chan i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmp_wr_i (sel & {2{~cfg.bank}}),
      .rld_wr_i (sel & {2{cfg.bank}}),
      .wdata_i  (wdata_i),
      .reload_i (reload),
      .phase_i  (phase),
      .cmp_o    (cmp_q[c]),
      .rld_o    (rld_q[c]),
      .pwm_o    (pwm_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CFG)         rdata_o = {cfg.bank, cfg.irq_en, cfg.flag, 3'b000, cfg.len};
    else if (addr_i == A_CNT_LO) rdata_o = cnt_rd[7:0];
    else if (addr_i == A_CNT_HI) rdata_o = cnt_rd[15:8];
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == AW'(4 + 2 * c))
        rdata_o = cfg.bank ? rld_q[c][7:0] : cmp_q[c][7:0];
      else if (addr_i == AW'(5 + 2 * c))
        rdata_o = 8'(cfg.bank ? rld_q[c][CMP_W-1:8] : cmp_q[c][CMP_W-1:8]);
    end
  end

  a_r1_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CFG) |-> (rdata_o[4:2] == 3'b000));

  a_r3_flag_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_ovf |=> cfg.flag);

  a_r6_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cfg.irq_en && cfg.flag));

endmodule

// File: tb/test_vcpwm_unit.sv
`timescale 1ns/1ps
module test_vcpwm_unit;

  localparam int NCH = 3;
  localparam int CW  = 12;
  localparam int AW  = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           run_i;
  logic           wr_en_i;
  logic [AW-1:0]  addr_i;
  logic [7:0]     wdata_i;
  logic [7:0]     rdata_o;
  logic [NCH-1:0] pwm_o;
  logic           irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  vcpwm_unit #(.NUM_CH(NCH), .CNT_W(CW)) i_vcpwm_unit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pwm_o   (pwm_o),
    .irq_o   (irq_o)
  );

  // {write, addr, wdata, expected read of addr}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h1c, 8'h00},
    {1'b1, 8'h00, 8'hff, 8'he3},
    {1'b1, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h04, 8'ha5, 8'ha5},
    {1'b1, 8'h05, 8'hff, 8'h0f},
    {1'b1, 8'h00, 8'h80, 8'h80},
    {1'b1, 8'h04, 8'h3c, 8'h3c},
    {1'b1, 8'h05, 8'h07, 8'h07},
    {1'b1, 8'h00, 8'h00, 8'h00},
    {1'b0, 8'h04, 8'h00, 8'ha5},
    {1'b0, 8'h05, 8'h00, 8'h0f},
    {1'b1, 8'h00, 8'h80, 8'h80},
    {1'b0, 8'h04, 8'h00, 8'h3c},
    {1'b1, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk_i);
    addr_i = AW'(a);
    #1 d = int'(rdata_o);
  endtask

  task automatic rd_cnt(output int c);
    @(negedge clk_i);
    addr_i = AW'(1);
    #0.5 c = int'(rdata_o);
    addr_i = AW'(2);
    #0.5 c = c | (int'(rdata_o) << 8);
  endtask

  task automatic step();
    @(negedge clk_i); run_i = 1'b1;
    @(negedge clk_i); run_i = 1'b0;
  endtask

  task automatic goto_low(input int m, input int tgt);
    int c;
    rd_cnt(c);
    while ((c & m) != tgt) begin
      step();
      rd_cnt(c);
    end
  endtask

  task automatic sample();
    @(negedge clk_i);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, c;
    rst_ni = 1'b0; run_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R10 pwm", int'(pwm_o), 0);
    chk("R10 irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    rd(0, v);   chk("R10 cfg", v, 0);
    rd_cnt(c);  chk("R10 cnt", c, 0);

    // R2 count and hold
    step();
    rd_cnt(c);  chk("R2 step", c, 1);
    repeat (3) @(negedge clk_i);
    rd_cnt(c);  chk("R2 hold", c, 1);

    // register table: R1 config layout, R7 bank routing
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) wr(int'(VEC[i][23:16]), int'(VEC[i][15:8]));
      rd(int'(VEC[i][23:16]), v);
      chk(VEC[i][23:16] == 8'h00 ? "R1 table" : "R7 table", v, int'(VEC[i][7:0]));
    end

    // R3 each length: flag only on carry out of bit N-1
    for (int l = 0; l < 4; l++) begin
      int m;
      m = (1 << (8 + l)) - 1;
      wr(0, l);
      goto_low(m, m - 1);
      wr(0, l);
      step();
      rd(0, v);   chk("R3 no flag below top", v & 8'h20, 0);
      step();
      rd(0, v);   chk("R3 flag at top", v & 8'h20, 8'h20);
      rd_cnt(c);  chk("R3 low bits wrapped", c & m, 0);
    end

    // R4 sticky flag, software set and clear
    wr(0, 8'h20);
    repeat (5) @(negedge clk_i);
    rd(0, v);   chk("R4 sw set sticks", v, 8'h20);
    wr(0, 8'h00);
    rd(0, v);   chk("R4 sw clear", v, 8'h00);

    // R6 interrupt gating
    wr(0, 8'h20); sample(); chk("R6 flag no enable", int'(irq_o), 0);
    wr(0, 8'h60); sample(); chk("R6 flag and enable", int'(irq_o), 1);
    wr(0, 8'h40); sample(); chk("R6 enable no flag", int'(irq_o), 0);
    wr(0, 8'h00);

    // R5 hardware set against software clear in one clock
    goto_low(8'hff, 8'hff);
    @(negedge clk_i);
    run_i = 1'b1; wr_en_i = 1'b1; addr_i = AW'(0); wdata_i = 8'h00;
    @(negedge clk_i);
    run_i = 1'b0; wr_en_i = 1'b0;
    rd(0, v);   chk("R5 set wins", v, 8'h20);

    // R8 compare: ch0=3, ch1=0, ch2=256 in 8-bit length
    wr(0, 8'h00);
    wr(4, 3);  wr(5, 0);
    wr(6, 0);  wr(7, 0);
    wr(8, 0);  wr(9, 1);
    goto_low(8'hff, 8'hff);
    sample(); chk("R8 phase 255", int'(pwm_o), 3'b100);
    step(); sample(); chk("R8 phase 0", int'(pwm_o), 3'b101);
    step(); step(); sample(); chk("R8 phase 2", int'(pwm_o), 3'b101);
    step(); sample(); chk("R8 phase 3", int'(pwm_o), 3'b100);

    // R9 reload in 9-bit length
    wr(0, 8'h01);
    wr(4, 8'h10); wr(5, 0);
    wr(0, 8'h81);
    wr(4, 8'h64); wr(5, 0);
    wr(0, 8'h01);
    rd(4, v);   chk("R9 no early reload", v, 8'h10);
    goto_low(11'h1ff, 11'h1ff);
    step();
    rd(4, v);   chk("R9 reload at edge", v, 8'h64);

    // R9 reload ignored in 8-bit length
    wr(0, 8'h00);
    wr(6, 20); wr(7, 0);
    wr(0, 8'h80);
    wr(6, 50); wr(7, 0);
    wr(0, 8'h00);
    goto_low(8'hff, 8'hff);
    step();
    rd(6, v);   chk("R9 8-bit keeps compare", v, 20);

    // R2 full-width wrap
    goto_low(12'hfff, 12'hfff);
    step();
    rd_cnt(c);  chk("R2 wrap", c, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule